// File: doc/BRIEF.md
# Password Retry Limit Counter

This block bounds the number of wrong password attempts that a secure memory accepts. It holds three settings: an 8-bit limit, an 8-bit attempt counter and a counting enable. Software or a loader programs them only while a configuration-mode input is high. Each single-cycle failed-attempt pulse advances the enabled counter by one. When the counter lands on the limit, a lockout flag is raised and held.

The counter does not start from zero. It starts from whatever value was programmed into it, so the number of wrong attempts permitted is the limit minus that starting value. A starting value above the limit is accepted without correction. The counter then climbs through 255, rolls to 0 and only then reaches the limit, which quietly grants extra attempts. Successful attempts leave everything untouched. Password comparison, storage of the settings across power loss and the response to lockout all live elsewhere.

Top module: `rpl_retry_guard`

## Requirements
- R1: On a synchronous active-low reset, the counter, the limit and the enable all clear to 0, and lockout deasserts.
- R2: Writes to the limit, the counter or the enable take effect only in a cycle where cfg_mode is 1. Otherwise the write strobes are ignored and the stored values are unchanged.
- R3: With the enable at 0, failed-attempt pulses never change the counter and never raise lockout.
- R4: A failed-attempt pulse with the enable at 1 and lockout at 0 raises the counter by one, modulo 256. The new value is visible after the clock edge that samples the pulse.
- R5: Lockout rises on the same edge on which an increment makes the counter equal to the limit. The number of failed pulses that reach lockout equals the limit minus the preset counter value.
- R6: While lockout is 1, failed-attempt pulses leave the counter unchanged and lockout stays at 1.
- R7: A configuration-mode write of the counter or of the limit clears lockout. A write of the enable alone does not clear it.
- R8: A preset above the limit is not corrected. The counter counts through 255, wraps to 0 and locks only on reaching the limit.
- R9: A successful-attempt pulse changes neither the counter nor lockout.
- R10: When a configuration-mode write of the counter or the limit falls in the same cycle as a failed-attempt pulse, the write takes effect and the pulse is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_mode | input | 1 | Configuration mode; gates all writes |
| cfg_wr_limit | input | 1 | Strobe: load limit from cfg_data |
| cfg_wr_count | input | 1 | Strobe: load counter from cfg_data |
| cfg_wr_enable | input | 1 | Strobe: load enable from cfg_enable_bit |
| cfg_data | input | 8 | Value for limit or counter writes |
| cfg_enable_bit | input | 1 | Value for enable writes |
| attempt_fail | input | 1 | Single-cycle failed-attempt pulse |
| attempt_pass | input | 1 | Single-cycle successful-attempt pulse |
| count_q | output | 8 | Current counter value |
| limit_q | output | 8 | Current limit value |
| enable_q | output | 1 | Current enable bit |
| lockout | output | 1 | Lockout flag |

## Verification
The hardest situation to reach is the wrap case. The counter has to cross 255 into 0 before it meets the limit. The bench gets there by presetting the counter to 254 with a limit of 2 in configuration mode. It then pulses four failures and checks after each one that lockout stays low until the fourth. A second awkward case is a counter write and a failure landing on the same edge. The bench drives both in one cycle and expects the written value.

// File: rtl/rpl_pkg.sv
// Package: shared width and helper type for the retry limit block.
// Assumes an 8-bit counter by default; every module takes the width from here.
package rpl_pkg;
    localparam int unsigned RPL_W = 8;
    typedef logic [RPL_W-1:0] rpl_val_t;
endpackage

// File: rtl/rpl_cfg_regs.sv
// Holds the limit value and the counting enable.
// Assumes the write strobes arrive already qualified by configuration mode.
module rpl_cfg_regs #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_mode,
    input  logic         lim_wr,
    input  logic         en_wr,
    input  logic [W-1:0] wr_data,
    input  logic         wr_en_bit,
    output logic [W-1:0] limit,
    output logic         enable
);
    // Load the limit on a qualified write; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      limit <= '0;
        else if (lim_wr) limit <= wr_data;
    end

    // Load the enable on a qualified write; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     enable <= 1'b0;
        else if (en_wr) enable <= wr_en_bit;
    end

    // R2
    cfg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mode |=> ($stable(limit) && $stable(enable)));
endmodule

// File: rtl/rpl_counter.sv
// Attempt counter: loadable in configuration mode, steps by one modulo 2**W.
// Assumes load and step are never both acted on; load wins.
module rpl_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] count,
    output logic [W-1:0] count_inc
);
    // Value the counter takes after one step (wraps naturally).
    always_comb count_inc = count + 1'b1;

    // Update the counter: reset, load, or step.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (load) count <= load_val;
        else if (step) count <= count_inc;
    end

    // R4
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (count == W'($past(count) + 1'b1)));
    // R10
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(load_val)));
endmodule

// File: rtl/rpl_lock.sv
// Lockout flag: set when a step lands the counter on the limit, held until
// a counter or limit rewrite or reset. Assumes clr and set are exclusive.
module rpl_lock #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic [W-1:0] next_count,
    input  logic [W-1:0] limit,
    input  logic         clr,
    output logic         locked
);
    logic hit;

    // Detect that the pending step reaches the limit.
    always_comb hit = step && (next_count == limit);

    // Maintain the sticky lockout flag.
    always_ff @(posedge clk) begin
        if (!rst_n)   locked <= 1'b0;
        else if (clr) locked <= 1'b0;
        else if (hit) locked <= 1'b1;
    end

    // R6
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !clr) |=> locked);
    // R7
    lock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !locked);
endmodule

// File: rtl/rpl_retry_guard.sv
// Top of the retry limit block. Qualifies writes with configuration mode,
// decides when a failure advances the counter, and exposes state for reading.
// Assumes attempt pulses are one cycle wide and synchronous to clk.
module rpl_retry_guard
    import rpl_pkg::*;
#(
    parameter int unsigned W = RPL_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_mode,
    input  logic         cfg_wr_limit,
    input  logic         cfg_wr_count,
    input  logic         cfg_wr_enable,
    input  logic [W-1:0] cfg_data,
    input  logic         cfg_enable_bit,
    input  logic         attempt_fail,
    input  logic         attempt_pass,
    output logic [W-1:0] count_q,
    output logic [W-1:0] limit_q,
    output logic         enable_q,
    output logic         lockout
);
    logic         lim_wr, cnt_wr, en_wr, step;
    logic [W-1:0] count_inc;

    // Gate write strobes with configuration mode and form the step request.
    always_comb begin
        lim_wr = cfg_mode && cfg_wr_limit;
        cnt_wr = cfg_mode && cfg_wr_count;
        en_wr  = cfg_mode && cfg_wr_enable;
        step   = attempt_fail && enable_q && !lockout && !lim_wr && !cnt_wr;
    end

    rpl_cfg_regs #(.W(W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .lim_wr(lim_wr),
        .en_wr(en_wr), .wr_data(cfg_data), .wr_en_bit(cfg_enable_bit),
        .limit(limit_q), .enable(enable_q)
    );

    rpl_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(cnt_wr), .load_val(cfg_data),
        .step(step), .count(count_q), .count_inc(count_inc)
    );

    rpl_lock #(.W(W)) u_lock (
        .clk(clk), .rst_n(rst_n), .step(step), .next_count(count_inc),
        .limit(limit_q), .clr(lim_wr || cnt_wr), .locked(lockout)
    );

    // R3
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_q && !cfg_mode) |=> ($stable(count_q) && !$rose(lockout)));
    // R5
    lock_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lockout) |-> (count_q == limit_q));
    // R9
    pass_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (attempt_pass && !attempt_fail && !cfg_mode)
            |=> ($stable(count_q) && $stable(lockout)));
endmodule

// File: tb/sim_rpl_retry_guard.sv
// Directed bench for rpl_retry_guard: one task per scenario.
module sim_rpl_retry_guard;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_mode = 1'b0, cfg_wr_limit = 1'b0, cfg_wr_count = 1'b0;
    logic       cfg_wr_enable = 1'b0, cfg_enable_bit = 1'b0;
    logic [7:0] cfg_data = 8'h00;
    logic       attempt_fail = 1'b0, attempt_pass = 1'b0;
    logic [7:0] count_q, limit_q;
    logic       enable_q, lockout;
    int         n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    rpl_retry_guard u0 (.*);

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive inputs for one clock, then return at the following falling edge.
    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
        cfg_mode = 0; cfg_wr_limit = 0; cfg_wr_count = 0; cfg_wr_enable = 0;
        attempt_fail = 0; attempt_pass = 0;
    endtask

    task automatic setup(input logic [7:0] lim, input logic [7:0] cnt, input logic en);
        cfg_mode = 1; cfg_wr_limit = 1; cfg_wr_count = 1; cfg_wr_enable = 1;
        cfg_enable_bit = en;
        cfg_data = lim; cfg_wr_count = 0; cfg_wr_enable = 1;
        cycle();
        cfg_mode = 1; cfg_wr_count = 1; cfg_data = cnt;
        cycle();
    endtask

    task automatic fail_pulse();
        attempt_fail = 1;
        cycle();
    endtask

    task automatic t_reset();
        check("R1 count", count_q, 0);
        check("R1 limit", limit_q, 0);
        check("R1 enable", enable_q, 0);
        check("R1 lockout", lockout, 0);
    endtask

    task automatic t_cfg_gate();
        cfg_mode = 0; cfg_wr_limit = 1; cfg_wr_count = 1; cfg_wr_enable = 1;
        cfg_enable_bit = 1; cfg_data = 8'd9;
        cycle();
        check("R2 limit gated", limit_q, 0);
        check("R2 count gated", count_q, 0);
        check("R2 enable gated", enable_q, 0);
        setup(8'd9, 8'd4, 1'b1);
        check("R2 limit written", limit_q, 9);
        check("R2 count written", count_q, 4);
        check("R2 enable written", enable_q, 1);
    endtask

    task automatic t_disabled();
        setup(8'd3, 8'd0, 1'b0);
        for (int i = 0; i < 5; i++) fail_pulse();
        check("R3 count frozen", count_q, 0);
        check("R3 no lockout", lockout, 0);
    endtask

    task automatic t_count_lock();
        setup(8'd5, 8'd2, 1'b1);
        fail_pulse();
        check("R4 first step", count_q, 3);
        fail_pulse();
        check("R4 second step", count_q, 4);
        check("R5 not yet locked", lockout, 0);
        fail_pulse();
        check("R5 count at limit", count_q, 5);
        check("R5 locked after limit-preset", lockout, 1);
    endtask

    task automatic t_locked();
        fail_pulse(); fail_pulse();
        check("R6 count held", count_q, 5);
        check("R6 lockout held", lockout, 1);
        attempt_pass = 1;
        cycle();
        check("R9 pass count", count_q, 5);
        check("R9 pass lockout", lockout, 1);
        cfg_mode = 1; cfg_wr_enable = 1; cfg_enable_bit = 1;
        cycle();
        check("R7 enable write keeps lock", lockout, 1);
        cfg_mode = 1; cfg_wr_limit = 1; cfg_data = 8'd8;
        cycle();
        check("R7 limit write clears lock", lockout, 0);
        fail_pulse();
        check("R7 counting resumes", count_q, 6);
    endtask

    task automatic t_wrap();
        setup(8'd2, 8'd254, 1'b1);
        fail_pulse();
        check("R8 at 255", count_q, 255);
        fail_pulse();
        check("R8 wrapped to 0", count_q, 0);
        check("R8 no lock at wrap", lockout, 0);
        fail_pulse();
        check("R8 no lock at 1", lockout, 0);
        fail_pulse();
        check("R8 count at limit", count_q, 2);
        check("R8 locked after wrap", lockout, 1);
    endtask

    task automatic t_collision();
        setup(8'd20, 8'd3, 1'b1);
        cfg_mode = 1; cfg_wr_count = 1; cfg_data = 8'd7; attempt_fail = 1;
        cycle();
        check("R10 write wins", count_q, 7);
        cfg_mode = 1; cfg_wr_limit = 1; cfg_data = 8'd8; attempt_fail = 1;
        cycle();
        check("R10 fail dropped on limit write", count_q, 7);
        check("R10 no lock", lockout, 0);
    endtask

    initial begin : wdog
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        t_reset();
        t_cfg_gate();
        t_disabled();
        t_count_lock();
        t_locked();
        t_wrap();
        t_collision();
        rst_n = 0;
        cycle();
        rst_n = 1;
        t_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule